// File: doc/BRIEF.md
# Ingress Leaky-Bucket Credit Pacer

This block sits on the receive side of a credit-based serial link. It limits how fast the peer transmitter can send by deciding when each receiver-ready credit goes back to it. A bucket occupancy counter gains one token for every frame that has fully arrived. It loses tokens at a programmable rate, set by a fractional increment that is added to an accumulator on every clock. Frames that have been switched onward add to a count of pending credit returns. Each clock cycle the block decides whether one of those returns may be issued.

The decision depends on where the occupancy sits relative to two programmable thresholds:

- **At or below the lower threshold:** pending returns go out back to back.
- **Between the thresholds:** a pacing timer lets out at most one return per programmed interval.
- **Above the upper threshold:** every return is withheld. Once the occupancy drops again, the withheld backlog is released through the same paced path, not in a burst.

Software computes the leak rate, the thresholds and the interval, and drives them as static configuration inputs. A limiter-enable input turns all gating off.

Top module: `rx_credit_pacer`

## Requirements
- R1: After reset is released, `credit_rdy_o` is low, the pending-return count is zero, the occupancy is zero and the pacing counter is zero.
- R2: Each cycle with `frame_fwd_i` high adds one pending return. Each one-cycle pulse on `credit_rdy_o` removes one. Below the cap, the number of pulses equals the number of forwarded frames.
- R3: With `cfg_limit_en_i` low, pending returns are issued one per cycle whatever the occupancy. A forward strobe sampled at clock edge k gives a pulse on `credit_rdy_o` after edge k+1.
- R4: When the occupancy is at or below `cfg_low_thr_i`, one pending return is issued in that cycle. The occupancy used for every threshold comparison is the value after that cycle's fill and leak.
- R5: When the occupancy is above `cfg_low_thr_i` and at or below `cfg_high_thr_i`, a return is issued only if at least `cfg_pace_ivl_i` cycles have passed since the previous issued return. An interval of 0 acts as 1, and the count since reset starts at zero.
- R6: When the occupancy is above `cfg_high_thr_i`, no return is issued. Withheld returns resume under the rules of R4 or R5 once the occupancy is at or below the upper threshold again.
- R7: Every clock adds `cfg_leak_inc_i` to a FRAC_W-bit accumulator, and a carry out of it removes one token. The occupancy never goes below zero.
- R8: Every `frame_rcvd_i` cycle adds one token, saturating at OCC_MAX. A fill and a leak in the same cycle cancel.
- R9: The pending count never exceeds BUF_CNT. A forward strobe that would push it past BUF_CNT is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_rcvd_i | input | 1 | One-cycle strobe: a complete frame has arrived |
| frame_fwd_i | input | 1 | One-cycle strobe: a stored frame has been forwarded |
| cfg_limit_en_i | input | 1 | 1 = threshold and pacing gating active; 0 = bypass |
| cfg_leak_inc_i | input | FRAC_W | Leak increment added to the accumulator every clock |
| cfg_low_thr_i | input | OCC_W | Lower occupancy threshold |
| cfg_high_thr_i | input | OCC_W | Upper occupancy threshold |
| cfg_pace_ivl_i | input | PACE_W | Minimum spacing in cycles between paced returns |
| credit_rdy_o | output | 1 | One-cycle request to send one receiver-ready primitive |

## Verification
The assertions take the configuration inputs as quasi-static: they are written between resets or during idle stretches, never in the middle of a release decision. They also assume the two strobes are single-cycle and synchronous.

The stimulus changes configuration only at falling edges, outside any edge where the design samples it. A sweep covers every combination of a small set of thresholds, intervals and leak increments, and resets the design between combinations. A bench-side arithmetic model of the occupancy, the pending count and the pacing spacing predicts every output pulse.

// File: rtl/cp_pkg.sv
package cp_pkg;

  // Occupancy band used to pick the credit release policy.
  typedef enum logic [1:0] {
    REG_LOW  = 2'd0,
    REG_MID  = 2'd1,
    REG_HIGH = 2'd2
  } occ_region_e;

endpackage

// File: rtl/cp_bucket.sv
module cp_bucket
  import cp_pkg::*;
#(
  parameter int FRAC_W  = 12,
  parameter int OCC_MAX = 255,
  parameter int OCC_W   = $clog2(OCC_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_i,
  input  logic [FRAC_W-1:0] leak_inc_i,
  input  logic [OCC_W-1:0]  low_thr_i,
  input  logic [OCC_W-1:0]  high_thr_i,
  output occ_region_e       region_o
);

  localparam int SUM_W = FRAC_W + 1;
  localparam logic [OCC_W-1:0] OCC_TOP = OCC_W'(OCC_MAX);

  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [SUM_W-1:0]  acc_sum;
  logic              leak_tok;
  logic [OCC_W-1:0]  occ_q, occ_d, occ_filled;
  logic              occ_en;

  // Fractional leak: a carry out of the accumulator removes one token.
  always_comb begin
    acc_sum  = {1'b0, acc_q} + {1'b0, leak_inc_i};
    leak_tok = acc_sum[FRAC_W];
    acc_d    = acc_sum[FRAC_W-1:0];
  end

  // Fill first, then leak, so a fill and a leak in one cycle cancel.
  always_comb begin
    occ_filled = occ_q;
    if (fill_i && (occ_q != OCC_TOP)) begin
      occ_filled = occ_q + 1'b1;
    end
    occ_d = occ_filled;
    if (leak_tok && (occ_filled != '0)) begin
      occ_d = occ_filled - 1'b1;
    end
    occ_en = (occ_d != occ_q);
  end

  // Band decision on the post-update occupancy; a tie goes to the lower band.
  always_comb begin
    if (occ_d <= low_thr_i) begin
      region_o = REG_LOW;
    end else if (occ_d <= high_thr_i) begin
      region_o = REG_MID;
    end else begin
      region_o = REG_HIGH;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
    end else if (occ_en) begin
      occ_q <= occ_d;
    end
  end

endmodule

// File: rtl/cp_pace_timer.sv
module cp_pace_timer #(
  parameter int PACE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [PACE_W-1:0] ivl_i,
  output logic              ready_o
);

  localparam logic [PACE_W-1:0] CNT_TOP = {PACE_W{1'b1}};

  logic [PACE_W-1:0] cnt_q, cnt_d;
  logic [PACE_W-1:0] ivl_eff;
  logic              cnt_en;

  // Cycles elapsed since the last issued return, saturating.
  always_comb begin
    ivl_eff = (ivl_i == '0) ? PACE_W'(1) : ivl_i;
    ready_o = (cnt_q >= (ivl_eff - 1'b1));
    if (issue_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    cnt_en = issue_i || (cnt_q != CNT_TOP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/cp_credit_ledger.sv
module cp_credit_ledger #(
  parameter int BUF_CNT = 32,
  parameter int PEND_W  = $clog2(BUF_CNT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fwd_i,
  input  logic grant_i,
  output logic issue_o,
  output logic credit_o
);

  localparam logic [PEND_W-1:0] PEND_CAP = PEND_W'(BUF_CNT);

  logic [PEND_W-1:0] pend_q, pend_d, pend_left;
  logic              accept;
  logic              pend_en;
  logic              credit_q;

  // Issue from the registered count; the new forward joins afterwards.
  always_comb begin
    issue_o   = (pend_q != '0) && grant_i;
    pend_left = pend_q - PEND_W'(issue_o);
    accept    = fwd_i && (pend_left < PEND_CAP);
    pend_d    = pend_left + PEND_W'(accept);
    pend_en   = issue_o || accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      credit_q <= 1'b0;
    end else begin
      credit_q <= issue_o;
    end
  end

  assign credit_o = credit_q;

endmodule

// File: rtl/rx_credit_pacer.sv
module rx_credit_pacer
  import cp_pkg::*;
#(
  parameter int FRAC_W  = 12,
  parameter int OCC_MAX = 255,
  parameter int BUF_CNT = 32,
  parameter int PACE_W  = 12,
  localparam int OCC_W  = $clog2(OCC_MAX + 1),
  localparam int PEND_W = $clog2(BUF_CNT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_rcvd_i,
  input  logic              frame_fwd_i,
  input  logic              cfg_limit_en_i,
  input  logic [FRAC_W-1:0] cfg_leak_inc_i,
  input  logic [OCC_W-1:0]  cfg_low_thr_i,
  input  logic [OCC_W-1:0]  cfg_high_thr_i,
  input  logic [PACE_W-1:0] cfg_pace_ivl_i,
  output logic              credit_rdy_o
);

  occ_region_e region;
  logic        pace_ready;
  logic        grant;
  logic        issue;

  cp_bucket #(
    .FRAC_W (FRAC_W),
    .OCC_MAX(OCC_MAX),
    .OCC_W  (OCC_W)
  ) u_bucket (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_i    (frame_rcvd_i),
    .leak_inc_i(cfg_leak_inc_i),
    .low_thr_i (cfg_low_thr_i),
    .high_thr_i(cfg_high_thr_i),
    .region_o  (region)
  );

  cp_pace_timer #(
    .PACE_W(PACE_W)
  ) u_pace (
    .clk    (clk),
    .rst_n  (rst_n),
    .issue_i(issue),
    .ivl_i  (cfg_pace_ivl_i),
    .ready_o(pace_ready)
  );

  // Release policy per band; bypass opens the gate unconditionally.
  always_comb begin
    if (!cfg_limit_en_i) begin
      grant = 1'b1;
    end else begin
      unique case (region)
        REG_LOW:  grant = 1'b1;
        REG_MID:  grant = pace_ready;
        default:  grant = 1'b0;
      endcase
    end
  end

  cp_credit_ledger #(
    .BUF_CNT(BUF_CNT),
    .PEND_W (PEND_W)
  ) u_ledger (
    .clk     (clk),
    .rst_n   (rst_n),
    .fwd_i   (frame_fwd_i),
    .grant_i (grant),
    .issue_o (issue),
    .credit_o(credit_rdy_o)
  );

endmodule

// File: rtl/cp_checker.sv
module cp_checker
  import cp_pkg::*;
#(
  parameter int BUF_CNT = 32,
  parameter int PEND_W  = 6,
  parameter int OCC_W   = 8,
  parameter int PACE_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              limit_en,
  input occ_region_e       region,
  input logic              issue,
  input logic              credit,
  input logic [PEND_W-1:0] pend,
  input logic [OCC_W-1:0]  occ,
  input logic [PACE_W-1:0] pace_cnt,
  input logic [PACE_W-1:0] ivl
);

  logic [PACE_W-1:0] ivl_floor;
  always_comb ivl_floor = (ivl == '0) ? PACE_W'(0) : (ivl - 1'b1);

  // R2: no request pulse without a pending return behind it
  p_no_empty_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |=> !credit);

  // R3: bypass drains one pending return per cycle
  p_bypass_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!limit_en && pend != '0) |=> credit);

  // R4: lower band releases at once
  p_low_immediate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_en && region == REG_LOW && pend != '0) |=> credit);

  // R5: mid band honours the pacing spacing
  p_mid_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_en && region == REG_MID && issue) |-> (pace_cnt >= ivl_floor));

  // R6: upper band withholds everything
  p_high_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_en && region == REG_HIGH) |=> !credit);

  // R7: occupancy moves by at most one token per cycle and never wraps
  p_occ_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (occ != $past(occ)) |-> ((occ == $past(occ) + 1'b1) || ($past(occ) == occ + 1'b1)));

  // R9: pending count stays within the buffer count
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PEND_W'(BUF_CNT));

endmodule

bind rx_credit_pacer cp_checker #(
  .BUF_CNT(BUF_CNT),
  .PEND_W (PEND_W),
  .OCC_W  (OCC_W),
  .PACE_W (PACE_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .limit_en(cfg_limit_en_i),
  .region  (region),
  .issue   (issue),
  .credit  (credit_rdy_o),
  .pend    (u_ledger.pend_q),
  .occ     (u_bucket.occ_q),
  .pace_cnt(u_pace.cnt_q),
  .ivl     (cfg_pace_ivl_i)
);

// File: tb/rx_credit_pacer_tb.sv
`timescale 1ns/1ps
module rx_credit_pacer_tb;

  localparam int FRAC_W  = 8;
  localparam int OCC_MAX = 31;
  localparam int BUF_CNT = 8;
  localparam int PACE_W  = 5;
  localparam int OCC_W   = 5;
  localparam int ACC_MOD = 256;
  localparam int T_TOP   = 31;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n;
  logic              frame_rcvd, frame_fwd, limit_en;
  logic [FRAC_W-1:0] leak_inc;
  logic [OCC_W-1:0]  low_thr, high_thr;
  logic [PACE_W-1:0] pace_ivl;
  logic              credit;

  rx_credit_pacer #(
    .FRAC_W(FRAC_W), .OCC_MAX(OCC_MAX), .BUF_CNT(BUF_CNT), .PACE_W(PACE_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_rcvd_i(frame_rcvd), .frame_fwd_i(frame_fwd),
    .cfg_limit_en_i(limit_en), .cfg_leak_inc_i(leak_inc), .cfg_low_thr_i(low_thr),
    .cfg_high_thr_i(high_thr), .cfg_pace_ivl_i(pace_ivl), .credit_rdy_o(credit)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1";

  // Bench-side arithmetic model
  int m_acc, m_occ, m_pend, m_t;
  bit exp_rdy;

  int cyc = 0;
  int pulses, min_gap, last_pulse, first_pulse;

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic clear_stats();
    pulses = 0; min_gap = 1000000; last_pulse = -1; first_pulse = -1;
  endtask

  task automatic model_step(bit rcv, bit fwd);
    int sum, o, ie, left;
    bit lk, g, iss;
    sum = m_acc + int'(leak_inc);
    lk = (sum >= ACC_MOD);
    m_acc = sum % ACC_MOD;
    o = m_occ + int'(rcv);
    if (o > OCC_MAX) o = OCC_MAX;
    if (lk && o > 0) o = o - 1;
    ie = (pace_ivl == 0) ? 1 : int'(pace_ivl);
    if (!limit_en) g = 1'b1;
    else if (o <= int'(low_thr)) g = 1'b1;
    else if (o <= int'(high_thr)) g = (m_t >= ie - 1);
    else g = 1'b0;
    iss = (m_pend > 0) && g;
    left = m_pend - int'(iss);
    if (fwd && left < BUF_CNT) left = left + 1;
    m_pend = left;
    m_t = iss ? 0 : ((m_t == T_TOP) ? T_TOP : m_t + 1);
    m_occ = o;
    exp_rdy = iss;
  endtask

  task automatic tick(bit rcv, bit fwd);
    frame_rcvd = rcv;
    frame_fwd = fwd;
    model_step(rcv, fwd);
    @(posedge clk);
    @(negedge clk);
    cyc++;
    check(tag, int'(credit), int'(exp_rdy));
    if (credit) begin
      if (last_pulse >= 0 && (cyc - last_pulse) < min_gap) min_gap = cyc - last_pulse;
      if (first_pulse < 0) first_pulse = cyc;
      last_pulse = cyc;
      pulses++;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    frame_rcvd = 1'b0;
    frame_fwd = 1'b0;
    repeat (2) @(negedge clk);
    m_acc = 0; m_occ = 0; m_pend = 0; m_t = 0; exp_rdy = 1'b0;
    rst_n = 1'b1;
    clear_stats();
  endtask

  task automatic set_cfg(bit en, int inc, int lo, int hi, int iv);
    limit_en = en;
    leak_inc = FRAC_W'(inc);
    low_thr  = OCC_W'(lo);
    high_thr = OCC_W'(hi);
    pace_ivl = PACE_W'(iv);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    int fwd_at;
    logic [15:0] lfsr;
    int incs [4];

    rst_n = 1'b0;
    frame_rcvd = 1'b0;
    frame_fwd = 1'b0;
    set_cfg(1'b1, 0, 3, 6, 8);

    // R1: reset state, output idle
    do_reset();
    tag = "R1";
    check("R1", int'(credit), 0);
    idle(3);
    check("R1", pulses, 0);

    // R3: bypass drains one per cycle, two edges after the forward
    do_reset();
    set_cfg(1'b0, 0, 0, 0, 8);
    tag = "R3";
    for (int i = 0; i < 10; i++) tick(1'b1, 1'b0);
    fwd_at = cyc + 1;
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b1);
    idle(3);
    check("R3 count", pulses, 5);
    check("R3 spacing", min_gap, 1);
    check("R3 latency", first_pulse, fwd_at + 1);

    // R4 and R2: lower band, back-to-back release
    do_reset();
    set_cfg(1'b1, 0, 3, 6, 8);
    tag = "R4";
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b1);
    idle(4);
    check("R4 spacing", min_gap, 1);
    check("R2 count equals forwards", pulses, 4);

    // R5: mid band, spaced by the interval
    do_reset();
    set_cfg(1'b1, 0, 3, 6, 8);
    tag = "R5";
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b1);
    idle(40);
    check("R5 count", pulses, 4);
    check("R5 spacing", min_gap, 8);

    // R6: upper band holds, then paced or immediate resume
    do_reset();
    set_cfg(1'b1, 0, 3, 6, 8);
    tag = "R6";
    for (int i = 0; i < 8; i++) tick(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b1);
    idle(40);
    check("R6 hold", pulses, 0);
    leak_inc = FRAC_W'(128);
    idle(60);
    check("R6 resume", pulses, 3);

    // R9: cap on pending returns
    do_reset();
    set_cfg(1'b1, 0, 0, 0, 8);
    tag = "R9";
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    for (int i = 0; i < 12; i++) tick(1'b0, 1'b1);
    idle(3);
    check("R9 held", pulses, 0);
    limit_en = 1'b0;
    idle(12);
    check("R9 cap", pulses, BUF_CNT);

    // R7: leaking from empty leaves the bucket at zero
    do_reset();
    set_cfg(1'b1, 255, 0, 0, 31);
    tag = "R7";
    idle(60);
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b1);
    idle(3);
    check("R7 floor", pulses, 3);
    check("R7 spacing", min_gap, 1);

    // R8: fill and leak in the same cycle cancel
    do_reset();
    set_cfg(1'b1, 255, 1, 1, 31);
    tag = "R8";
    for (int i = 0; i < 30; i++) tick(1'b1, 1'b1);
    idle(2);
    check("R8 net", pulses, 30);

    // Sweep of thresholds, intervals and leak increments
    incs[0] = 0; incs[1] = 40; incs[2] = 128; incs[3] = 250;
    lfsr = 16'hACE1;
    tag = "R4 R5 R6 R7 R8 sweep";
    for (int lo = 0; lo < 4; lo++) begin
      for (int ho = 0; ho < 3; ho++) begin
        for (int iv = 0; iv < 3; iv++) begin
          for (int ii = 0; ii < 4; ii++) begin
            do_reset();
            set_cfg(1'b1, incs[ii], lo, lo + ((ho == 0) ? 0 : (ho == 1) ? 2 : 5),
                    (iv == 0) ? 1 : (iv == 1) ? 3 : 6);
            for (int c = 0; c < 150; c++) begin
              lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
              tick(lfsr[0] & (lfsr[3] | lfsr[7]), lfsr[5]);
            end
          end
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule